// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns a small set of asynchronous external interrupt pins into clean request flags for a downstream interrupt controller. Every pin has its own eight-bit control register. The register selects level or edge sensing, sets the active polarity, holds a three-bit priority that is passed straight through to the controller, and carries the request flag itself. Each pin goes through a multi-flop synchronizer. The block then tests the synchronized value against the chosen condition, sets the request flag, and clears the flag when the controller acknowledges that source.

One polarity bit serves both sensing modes, and it pairs them in a crossed way. With polarity 0, a high level or a falling edge is active. With polarity 1, a low level or a rising edge is active. Software reaches the registers through a plain one-cycle write strobe with a pin select and a combinational read port. There is no streaming data path, so there are no valid/ready handshakes. The acknowledge inputs are single-cycle pulses, one per pin, and they need no back-pressure.

Top module: `ext_irq_detect`

## Requirements
- R1: The block serves NUM_PINS pins (default 3). Each pin has an independent control register and its own `irq_req_o` bit, and an event on one pin never changes another pin's request.
- R2: A pin change present before rising clock edge E first shows on `irq_req_o` just after edge E+2 (two synchronizer flops, then the request flop), and not earlier.
- R3: In edge mode (control bit 5 = 0), polarity 0 (bit 4) sets the request on a high-to-low pin transition and polarity 1 sets it on a low-to-high transition. The opposite transition sets nothing.
- R4: In level mode (bit 5 = 1), the request is set on every cycle in which the synchronized pin is high (polarity 0) or low (polarity 1).
- R5: A one-cycle acknowledge clears the request at the next edge. In level mode with the pin still active, the request is low for exactly one cycle and is then set again.
- R6: An edge event detected in the same cycle as an acknowledge keeps the request set, so the new event is not lost.
- R7: Reset clears every control register to 0 (edge mode, polarity 0, priority 0, no request), so all `irq_req_o` bits are low.
- R8: A register write that changes polarity or mode does not by itself create an edge request while the pin is held steady.
- R9: The control register layout is: bits [2:0] priority (read/write, driven on `irq_prio_o`), bit 3 request (readable; software may write 0 or 1), bit 4 polarity, bit 5 mode, bits [7:6] read 0. A detection beats a software write of the request bit, and an acknowledge beats a software write.
- R10: `rd_data_o` combinationally returns the register chosen by `rd_sel_i`. A select at or above NUM_PINS reads 0, and a write to such a select changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W | Pin register selected for writing |
| wr_data_i | input | 8 | Register write data |
| rd_sel_i | input | SEL_W | Pin register selected for reading |
| rd_data_o | output | 8 | Selected register contents |
| irq_ack_i | input | NUM_PINS | Per-pin acknowledge pulse from the controller |
| irq_req_o | output | NUM_PINS | Per-pin request flags |
| irq_prio_o | output | NUM_PINS*3 | Priority field of each pin, pin 0 in the low bits |

## Verification
The bench builds the block with its default values: three pins and a two-stage synchronizer. With three pins the two-bit select has one unused code, so the bench can write to and read from that code and confirm that nothing changes and that the read returns zero. The two-stage synchronizer fixes request latency at three edges, and the bench checks both sides of that boundary. It also covers all four combinations of mode and polarity, acknowledge colliding with an edge, and polarity changes made while a pin is held steady.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int CTRL_W   = 8;
  localparam int PRIO_W   = 3;
  localparam int BIT_REQ  = 3;
  localparam int BIT_POL  = 4;
  localparam int BIT_MODE = 5;

  typedef struct packed {
    logic              level_mode;
    logic              polarity;
    logic              request;
    logic [PRIO_W-1:0] prio;
  } ctrl_view_t;

  function automatic logic [CTRL_W-1:0] pack_ctrl(ctrl_view_t v);
    logic [CTRL_W-1:0] r;
    r                = '0;
    r[PRIO_W-1:0]    = v.prio;
    r[BIT_REQ]       = v.request;
    r[BIT_POL]       = v.polarity;
    r[BIT_MODE]      = v.level_mode;
    return r;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_channel.sv
module ext_irq_channel
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_sync_i,
  input  logic              wr_hit_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              ack_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              req_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic [PRIO_W-1:0] prio_q;
  logic              pol_q;
  logic              lvl_q;
  logic              req_q;
  logic              prev_act_q;

  logic act;
  logic edge_hit;
  logic level_hit;
  logic set_req;
  logic new_pol;

  // polarity 0: high level / falling edge; polarity 1: low level / rising edge
  assign act       = pin_sync_i ^ pol_q;
  assign edge_hit  = !lvl_q && prev_act_q && !act;
  assign level_hit = lvl_q && act;
  assign set_req   = edge_hit || (level_hit && !ack_i);
  assign new_pol   = wr_data_i[BIT_POL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q     <= '0;
      pol_q      <= 1'b0;
      lvl_q      <= 1'b0;
      req_q      <= 1'b0;
      prev_act_q <= 1'b0;
    end else begin
      if (wr_hit_i) begin
        prio_q     <= wr_data_i[PRIO_W-1:0];
        pol_q      <= new_pol;
        lvl_q      <= wr_data_i[BIT_MODE];
        prev_act_q <= pin_sync_i ^ new_pol;
      end else begin
        prev_act_q <= act;
      end

      if (set_req)       req_q <= 1'b1;
      else if (ack_i)    req_q <= 1'b0;
      else if (wr_hit_i) req_q <= wr_data_i[BIT_REQ];
    end
  end

  ctrl_view_t view;
  always_comb begin
    view.level_mode = lvl_q;
    view.polarity   = pol_q;
    view.request    = req_q;
    view.prio       = prio_q;
  end

  assign ctrl_o = pack_ctrl(view);
  assign req_o  = req_q;
  assign prio_o = prio_q;

  a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> req_q);

  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q && act && !ack_i) |=> req_q);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !edge_hit) |=> !req_q);

  a_r8_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_i |=> (!$stable(pin_sync_i) || !edge_hit));

  a_r9_req_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> ($past(ack_i) || $past(wr_hit_i)));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        irq_pin_i,
  input  logic                       wr_en_i,
  input  logic [SEL_W-1:0]           wr_sel_i,
  input  logic [CTRL_W-1:0]          wr_data_i,
  input  logic [SEL_W-1:0]           rd_sel_i,
  output logic [CTRL_W-1:0]          rd_data_o,
  input  logic [NUM_PINS-1:0]        irq_ack_i,
  output logic [NUM_PINS-1:0]        irq_req_o,
  output logic [NUM_PINS*PRIO_W-1:0] irq_prio_o
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [CTRL_W-1:0]   ctrl_bank [NUM_PINS];

  ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(irq_pin_i),
    .sync_o (pin_sync)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chan
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_sel_i == SEL_W'(g));

    ext_irq_channel u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_sync_i(pin_sync[g]),
      .wr_hit_i  (wr_hit),
      .wr_data_i (wr_data_i),
      .ack_i     (irq_ack_i[g]),
      .ctrl_o    (ctrl_bank[g]),
      .req_o     (irq_req_o[g]),
      .prio_o    (irq_prio_o[g*PRIO_W +: PRIO_W])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rd_sel_i == SEL_W'(i)) rd_data_o = ctrl_bank[i];
    end
  end
endmodule

// File: tb/test_ext_irq_detect.sv
module test_ext_irq_detect;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] pin = '1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [N-1:0] ack = '0;
  logic [N-1:0] req;
  logic [N*3-1:0] prio;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_detect i_ext_irq_detect (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pin), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_ack_i(ack), .irq_req_o(req), .irq_prio_o(prio)
  );

  function automatic logic [7:0] cfg(logic mode, logic pol, logic rq, logic [2:0] pr);
    return {2'b00, mode, pol, rq, pr};
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ack(input int p);
    ack[p] = 1'b1;
    step(1);
    ack[p] = 1'b0;
  endtask

  task automatic t_reset();
    chk(req == '0, "R7 req after reset", req, 0);
    for (int i = 0; i < N; i++) begin
      rd_sel = 2'(i);
      #0;
      chk(rd_data == 8'h00, "R7 ctrl after reset", rd_data, 0);
    end
  endtask

  task automatic t_edge_fall_latency();
    pin[0] = 1'b0;
    step(2);
    chk(req[0] == 1'b0, "R2 not before third edge", req[0], 0);
    step(1);
    chk(req[0] == 1'b1, "R2/R3 falling edge pol0", req[0], 1);
    chk(req[2:1] == 2'b00, "R1 other pins untouched", req[2:1], 0);
    pulse_ack(0);
    chk(req[0] == 1'b0, "R5 ack clears edge request", req[0], 0);
    pin[0] = 1'b1;
    step(4);
    chk(req[0] == 1'b0, "R3 rising ignored pol0", req[0], 0);
  endtask

  task automatic t_edge_rise_pol1();
    wr(2'd1, cfg(1'b0, 1'b1, 1'b0, 3'd5));
    pin[1] = 1'b0;
    step(4);
    chk(req[1] == 1'b0, "R3 falling ignored pol1", req[1], 0);
    pin[1] = 1'b1;
    step(3);
    chk(req[1] == 1'b1, "R3 rising edge pol1", req[1], 1);
    chk(prio[5:3] == 3'd5, "R9 priority out", prio[5:3], 5);
    pulse_ack(1);
  endtask

  task automatic t_level_high();
    wr(2'd2, cfg(1'b1, 1'b0, 1'b0, 3'd2));
    step(1);
    chk(req[2] == 1'b1, "R4 high level pol0", req[2], 1);
    pulse_ack(2);
    chk(req[2] == 1'b0, "R5 one low cycle after ack", req[2], 0);
    step(1);
    chk(req[2] == 1'b1, "R5 level re-set", req[2], 1);
    pin[2] = 1'b0;
    step(3);
    pulse_ack(2);
    step(2);
    chk(req[2] == 1'b0, "R4 inactive level stays low", req[2], 0);
    pin[2] = 1'b1;
    wr(2'd2, cfg(1'b0, 1'b0, 1'b0, 3'd2));
    step(3);
  endtask

  task automatic t_level_low();
    wr(2'd0, cfg(1'b1, 1'b1, 1'b0, 3'd0));
    step(3);
    chk(req[0] == 1'b0, "R4 high pin ignored pol1", req[0], 0);
    pin[0] = 1'b0;
    step(3);
    chk(req[0] == 1'b1, "R4 low level pol1", req[0], 1);
    pin[0] = 1'b1;
    step(3);
    pulse_ack(0);
    step(1);
    chk(req[0] == 1'b0, "R5 cleared once inactive", req[0], 0);
    wr(2'd0, cfg(1'b0, 1'b0, 1'b0, 3'd0));
  endtask

  task automatic t_ack_collide();
    wr(2'd0, cfg(1'b0, 1'b0, 1'b1, 3'd0));
    chk(req[0] == 1'b1, "R9 software sets request", req[0], 1);
    pin[0] = 1'b0;
    step(2);
    ack[0] = 1'b1;
    step(1);
    ack[0] = 1'b0;
    chk(req[0] == 1'b1, "R6 edge beats ack", req[0], 1);
    pulse_ack(0);
    pin[0] = 1'b1;
    step(3);
  endtask

  task automatic t_cfg_quiet();
    wr(2'd0, cfg(1'b0, 1'b1, 1'b0, 3'd0));
    step(4);
    chk(req[0] == 1'b0, "R8 pol change no request", req[0], 0);
    wr(2'd0, cfg(1'b0, 1'b0, 1'b0, 3'd0));
    step(4);
    chk(req[0] == 1'b0, "R8 pol restore no request", req[0], 0);
  endtask

  task automatic t_regs();
    wr(2'd1, cfg(1'b1, 1'b1, 1'b0, 3'd7) | 8'hC0);
    rd_sel = 2'd1;
    #0;
    chk(rd_data == cfg(1'b1, 1'b1, 1'b0, 3'd7), "R9 readback layout", rd_data, cfg(1'b1, 1'b1, 1'b0, 3'd7));
    wr(2'd1, cfg(1'b0, 1'b0, 1'b0, 3'd1));
    wr(2'd3, 8'h3F);
    for (int i = 0; i < N; i++) begin
      rd_sel = 2'(i);
      #0;
      chk(rd_data[5:4] == 2'b00, "R10 unused select writes nothing", rd_data, 0);
    end
    rd_sel = 2'd3;
    #0;
    chk(rd_data == 8'h00, "R10 unused select reads 0", rd_data, 0);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = cfg(1'b0, 1'b0, 1'b1, 3'd0); ack[2] = 1'b1;
    step(1);
    wr_en = 1'b0; ack[2] = 1'b0;
    chk(req[2] == 1'b0, "R9 ack beats write", req[2], 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_edge_fall_latency();
    t_edge_rise_pol1();
    t_level_high();
    t_level_low();
    t_ack_collide();
    t_cfg_quiet();
    t_regs();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule